// File: doc/BRIEF.md
# Front-Panel Memory Indicator Register

This block holds the word shown on a processor's front-panel memory indicator lamps. The register is loaded only from the arithmetic register. There are three reasons to load it. The first is an operator examine request. The second is a software output aimed at the indicator, which passes only while a sticky program-enable flag is set. The third is an automatic capture during normal execution, taken when the current memory reference hits the address set on the panel switches.

The address compare accepts two kinds of hit. A full hit is an exact match over the whole address width. A fast-accumulator hit is a match on an access to one of the fast accumulators, where the switches select that accumulator and all their upper bits are zero. A hit counts only in a cycle that carries the memory-reference strobe. All load reasons merge into one load. The new word appears one clock after the trigger, and a one-cycle load strobe comes with it.

Top module: `mem_indicator`

## Requirements
- R1: Every load captures the `ar_word` value present in the cycle of the trigger. The new value shows on `ind_word` after the next rising clock edge, together with `ind_load` high for that one cycle.
- R2: An `examine_pulse` causes a load at the next edge, whatever the other inputs are.
- R3: A `prog_out_pulse` causes a load only if the program-enable flag was already set before that cycle.
- R4: A `prog_out_pulse` sets the program-enable flag and an `examine_pulse` clears it. When both come in the same cycle, the flag ends up clear.
- R5: With `mem_ref_strobe` high and `mem_addr` equal to `sw_addr` in all 18 bits, a load occurs. With the strobe high and no hit, no load occurs.
- R6: A fast-accumulator hit needs three things: `fast_acc` high, bits [3:0] of address and switches equal, and switch bits [17:4] all zero. It loads with the strobe even when the full addresses differ. It does not load if `fast_acc` is low or any upper switch bit is set.
- R7: An address hit without `mem_ref_strobe` causes no load.
- R8: Several triggers in one cycle produce exactly one load of that cycle's `ar_word`, and `ind_load` is low again in the following idle cycle.
- R9: In a cycle with no trigger, `ind_word` holds its value and `ind_load` stays low, even while `ar_word` changes.
- R10: Reset clears `ind_word` to zero, holds `ind_load` low and clears the program-enable flag. The flag is seen as clear because the first `prog_out_pulse` after reset does not load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ar_word | input | 36 | Arithmetic register word, the only load data source |
| mem_addr | input | 18 | Address of the current memory reference |
| fast_acc | input | 1 | Current reference targets a fast accumulator |
| sw_addr | input | 18 | Panel address switch setting |
| examine_pulse | input | 1 | Operator examine request, one cycle |
| prog_out_pulse | input | 1 | Software output to the indicator, one cycle |
| mem_ref_strobe | input | 1 | Qualifies the address compare for one reference |
| ind_word | output | 36 | Indicator register value |
| ind_load | output | 1 | High for the cycle after a load |

## Verification
The hidden program-enable flag is the hardest state to reach, because it shows only through whether a later software output loads. The stimulus walks the flag through each of its transitions: the blocked first output after reset, set, clear by examine, and examine together with output in one cycle. After each transition a probing `prog_out_pulse` exposes the flag state. The fast-accumulator path needs addresses whose full compare fails while the low bits match. Separate cases then break each qualifier in turn: `fast_acc`, the upper switch bits and the strobe.

// File: rtl/mi_pkg.sv
package mi_pkg;
  parameter int unsigned IND_DATA_W = 36;
  parameter int unsigned IND_ADDR_W = 18;
  parameter int unsigned IND_FAST_W = 4;
endpackage

// File: rtl/mi_rst_sync.sv
module mi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/mi_addr_cmp.sv
module mi_addr_cmp #(
  parameter int unsigned AW = 18,
  parameter int unsigned FW = 4
) (
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] sw_addr,
  input  logic          fast_acc,
  output logic          hit
);
  localparam int unsigned UW = AW - FW;

  logic fast_hit;
  logic full_hit;

  always_comb begin
    fast_hit = fast_acc
             && (sw_addr[AW-1:FW] == {UW{1'b0}})
             && (sw_addr[FW-1:0] == ref_addr[FW-1:0]);
    full_hit = (sw_addr == ref_addr);
    hit      = fast_hit | full_hit;
  end
endmodule

// File: rtl/mi_prog_gate.sv
module mi_prog_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic examine,
  input  logic prog_pulse,
  output logic prog_load,
  output logic en_q
);
  logic en_d;
  logic en_ce;

  always_comb begin
    en_ce = examine | prog_pulse;
    en_d  = en_q;
    if (examine)         en_d = 1'b0;
    else if (prog_pulse) en_d = 1'b1;
    prog_load = prog_pulse & en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_pulse && !examine) |=> en_q); // R4
  AST_EXAM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    examine |=> !en_q); // R4
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_pulse && !examine) |=> $stable(en_q)); // R3
endmodule

// File: rtl/mi_ind_reg.sv
module mi_ind_reg #(
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic [DW-1:0] src_word,
  output logic [DW-1:0] word_q,
  output logic          load_q
);
  logic [DW-1:0] word_d;

  always_comb begin
    word_d = load_req ? src_word : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= load_req;
      if (load_req) word_q <= word_d;
    end
  end

  AST_LOAD_TAKES_AR: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> (word_q == $past(src_word))); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_q |-> $stable(word_q)); // R9
endmodule

// File: rtl/mem_indicator.sv
module mem_indicator
  import mi_pkg::*;
#(
  parameter int unsigned DW = IND_DATA_W,
  parameter int unsigned AW = IND_ADDR_W,
  parameter int unsigned FW = IND_FAST_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ar_word,
  input  logic [AW-1:0] mem_addr,
  input  logic          fast_acc,
  input  logic [AW-1:0] sw_addr,
  input  logic          examine_pulse,
  input  logic          prog_out_pulse,
  input  logic          mem_ref_strobe,
  output logic [DW-1:0] ind_word,
  output logic          ind_load
);
  logic rst_n_s;
  logic addr_hit;
  logic prog_load;
  logic prog_en;
  logic load_req;

  mi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  mi_addr_cmp #(.AW(AW), .FW(FW)) u_cmp (
    .ref_addr (mem_addr),
    .sw_addr  (sw_addr),
    .fast_acc (fast_acc),
    .hit      (addr_hit)
  );

  mi_prog_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .examine    (examine_pulse),
    .prog_pulse (prog_out_pulse),
    .prog_load  (prog_load),
    .en_q       (prog_en)
  );

  always_comb begin
    load_req = examine_pulse | prog_load | (mem_ref_strobe & addr_hit);
  end

  mi_ind_reg #(.DW(DW)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_req (load_req),
    .src_word (ar_word),
    .word_q   (ind_word),
    .load_q   (ind_load)
  );

  AST_EXAM_LOADS: assert property (@(posedge clk) disable iff (!rst_n_s)
    examine_pulse |=> ind_load); // R2
  AST_HIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_ref_strobe && addr_hit) |=> ind_load); // R5
  AST_NO_STROBE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!examine_pulse && !prog_out_pulse && !mem_ref_strobe) |=> !ind_load); // R7
  AST_BLOCKED_PROG: assert property (@(posedge clk) disable iff (!rst_n_s)
    (prog_out_pulse && !prog_en && !examine_pulse && !mem_ref_strobe) |=> !ind_load); // R3
endmodule

// File: tb/test_mem_indicator.sv
module test_mem_indicator;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 36;
  localparam int AW = 18;

  typedef struct {
    logic          load;
    logic [DW-1:0] word;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] ar_word;
  logic [AW-1:0] mem_addr;
  logic          fast_acc;
  logic [AW-1:0] sw_addr;
  logic          examine_pulse;
  logic          prog_out_pulse;
  logic          mem_ref_strobe;
  logic [DW-1:0] ind_word;
  logic          ind_load;

  exp_t          sb_q[$];
  int            n_tests = 0;
  int            n_fail  = 0;
  bit            drv_done = 1'b0;
  bit            m_flag = 1'b0;
  logic [DW-1:0] m_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_indicator i_mem_indicator (
    .clk            (clk),
    .rst_n          (rst_n),
    .ar_word        (ar_word),
    .mem_addr       (mem_addr),
    .fast_acc       (fast_acc),
    .sw_addr        (sw_addr),
    .examine_pulse  (examine_pulse),
    .prog_out_pulse (prog_out_pulse),
    .mem_ref_strobe (mem_ref_strobe),
    .ind_word       (ind_word),
    .ind_load       (ind_load)
  );

  task automatic cyc(input logic [DW-1:0] ar, input logic [AW-1:0] ad,
                     input logic fa, input logic [AW-1:0] sw,
                     input logic ex, input logic po, input logic st,
                     input string req);
    exp_t e;
    logic hit;
    logic ld;
    @(negedge clk);
    ar_word = ar; mem_addr = ad; fast_acc = fa; sw_addr = sw;
    examine_pulse = ex; prog_out_pulse = po; mem_ref_strobe = st;
    hit = (sw == ad) || (fa && (sw[AW-1:4] == '0) && (sw[3:0] == ad[3:0]));
    ld  = ex || (po && m_flag) || (st && hit);
    if (ld) m_word = ar;
    if (ex)      m_flag = 1'b0;
    else if (po) m_flag = 1'b1;
    e.load = ld; e.word = m_word; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic idle(input logic [DW-1:0] ar, input string req);
    cyc(ar, 18'h0, 1'b0, 18'h3FFFF, 1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        n_tests++;
        if (ind_load !== e.load || ind_word !== e.word) begin
          n_fail++;
          $display("FAIL %s: load=%0b word=%h expected load=%0b word=%h",
                   e.req, ind_load, ind_word, e.load, e.word);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0;
    ar_word = 36'h5_A5A5_A5A5; mem_addr = '0; fast_acc = 1'b0; sw_addr = 18'h3FFFF;
    examine_pulse = 1'b0; prog_out_pulse = 1'b0; mem_ref_strobe = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (ind_word !== '0 || ind_load !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: load=%0b word=%h expected load=0 word=0", ind_load, ind_word);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    idle(36'h1_1111_1111, "R9 idle after reset");
    cyc(36'h2_2222_2222, 18'h0, 1'b0, 18'h3FFFF, 1'b0, 1'b1, 1'b0, "R10 first prog blocked");
    cyc(36'h3_3333_3333, 18'h0, 1'b0, 18'h3FFFF, 1'b0, 1'b1, 1'b0, "R3 prog with flag set");
    idle(36'h4_4444_4444, "R9 hold");
    cyc(36'h5_5555_5555, 18'h0, 1'b0, 18'h3FFFF, 1'b1, 1'b0, 1'b0, "R2 examine load");
    cyc(36'h6_6666_6666, 18'h0, 1'b0, 18'h3FFFF, 1'b0, 1'b1, 1'b0, "R4 flag cleared by examine");
    cyc(36'h7_7777_7777, 18'h0, 1'b0, 18'h3FFFF, 1'b0, 1'b1, 1'b0, "R3 prog reloads");
    cyc(36'h8_8888_8888, 18'h0, 1'b0, 18'h3FFFF, 1'b1, 1'b1, 1'b0, "R4 examine+prog");
    cyc(36'h9_9999_9999, 18'h0, 1'b0, 18'h3FFFF, 1'b0, 1'b1, 1'b0, "R4 examine wins clear");
    cyc(36'hA_0000_0001, 18'h2A5C3, 1'b0, 18'h2A5C3, 1'b0, 1'b0, 1'b1, "R5 full hit");
    cyc(36'hB_0000_0002, 18'h2A5C3, 1'b0, 18'h2A5C3, 1'b0, 1'b0, 1'b0, "R7 hit no strobe");
    cyc(36'hC_0000_0003, 18'h2A5C2, 1'b0, 18'h2A5C3, 1'b0, 1'b0, 1'b1, "R5 miss with strobe");
    cyc(36'hD_0000_0004, 18'h3FFF7, 1'b1, 18'h00007, 1'b0, 1'b0, 1'b1, "R6 fast hit");
    cyc(36'hE_0000_0005, 18'h3FFF7, 1'b0, 18'h00007, 1'b0, 1'b0, 1'b1, "R6 fast_acc low");
    cyc(36'hF_0000_0006, 18'h00007, 1'b1, 18'h10007, 1'b0, 1'b0, 1'b1, "R6 upper sw set");
    cyc(36'h0_1234_5678, 18'h00005, 1'b1, 18'h00005, 1'b0, 1'b0, 1'b1, "R6 fast+full hit");
    cyc(36'h0_0000_0000, 18'h0, 1'b0, 18'h3FFFF, 1'b0, 1'b1, 1'b0, "R3 prog sets flag");
    cyc(36'h0_CAFE_F00D, 18'h00100, 1'b0, 18'h00100, 1'b1, 1'b1, 1'b1, "R8 all triggers");
    idle(36'hF_FFFF_FFFF, "R8 single load then idle");
    idle(36'h0_0F0F_0F0F, "R1 AR change no load");
    cyc(36'h3_C3C3_C3C3, 18'h00001, 1'b0, 18'h3FFFF, 1'b1, 1'b0, 1'b1, "R1 examine captures AR");
    idle(36'h0, "R9 hold final");

    drv_done = 1'b1;
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule